// File: doc/BRIEF.md
# Dual-Law Voice Sample Compander

This block translates between two's-complement linear voice samples and 8-bit companded characters, in either of the two standard telephony companding laws. The law is picked per sample by a select input: low selects mu-law (14-bit linear range), high selects A-law (13-bit linear range). An encode path turns a linear sample into a line character, and an independent decode path turns a line character back into a linear sample.

Each path accepts a sample when its input valid is high and presents the result one clock later with its output valid raised. When the input valid is low the path's data output keeps its last value. A tie-off of the select inputs to zero gives mu-law operation. The reset is asynchronous on assertion and released through a two-stage synchronizer inside the block.

Top module: `g711_codec`

## Requirements
- R1: mu-law encode (select 0) of non-negative inputs gives a character with bit 7 set; 0 encodes to 8'hFF and any value of 8158 or more encodes to 8'h80.
- R2: mu-law encode of negative inputs gives bit 7 clear; magnitudes are clipped to 8158 before a bias of 33 is added, so -8192 encodes to 8'h00; every other code follows segment = leading-one position of (magnitude+33) minus 5, mantissa = the next four bits, whole character inverted.
- R3: A-law encode (select 1) takes the sample from bits 12:0, inverts the even bits (XOR 8'h55) of the {positive, segment, mantissa} code: 0 gives 8'hD5, 4095 gives 8'hAA, -4096 gives 8'h2A, -1 gives 8'h55.
- R4: In A-law, magnitudes below 32 use segment 0 with mantissa equal to magnitude/2 (linear), so input 2k (k 0..15) gives (8'h80 | k) XOR 8'h55.
- R5: mu-law decode returns the interval midpoint minus the bias: ((2*mantissa+33) << segment) - 33, negated when bit 7 of the character is 0; 8'hFF and 8'h7F give 0, 8'h80 gives 8031, 8'h00 gives -8031.
- R6: A-law decode returns the interval midpoint, sign-extended to 14 bits: segment 0 gives 2*mantissa+1, segment s gives (2*mantissa+33) << (s-1); 8'hD5 gives 1, 8'h55 gives -1, 8'hAA gives 4032, 8'h2A gives -4032.
- R7: Each path raises its output valid exactly one clock after an accepted input and carries that sample's result; back-to-back samples stream at one per clock.
- R8: While a path's input valid is low its output valid is low and its data output holds the last result.
- R9: In A-law encode, input bit 13 has no effect on the character.
- R10: After reset both output valids are low, the character output is 8'hFF and the linear output is 0.
- R11: The law select is sampled with each input, so consecutive samples may alternate laws with each result following its own law.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_law | input | 1 | Encode law: 0 mu-law, 1 A-law |
| enc_valid_in | input | 1 | Encode sample valid |
| enc_lin_in | input | 14 | Linear sample to encode (A-law uses bits 12:0) |
| enc_valid_out | output | 1 | Encoded character valid |
| enc_char_out | output | 8 | Encoded line character |
| dec_law | input | 1 | Decode law: 0 mu-law, 1 A-law |
| dec_valid_in | input | 1 | Character valid |
| dec_char_in | input | 8 | Line character to decode |
| dec_valid_out | output | 1 | Decoded sample valid |
| dec_lin_out | output | 14 | Decoded linear sample |

## Verification
The hardest conditions to reach are the edges of the number ranges: the single most negative input in each law, whose negation overflows the magnitude width and must be clipped, and the A-law seam between the linear segment 0 and segment 1 at magnitude 32. Directed tasks drive these exact values, then a back-to-back sweep that alternates the law on every cycle walks the whole input range in fixed strides and all 256 characters through the decoder, comparing against a bench model written from the segment formulas.

// File: rtl/g711_pkg.sv
package g711_pkg;
  localparam int LIN_W    = 14;
  localparam int A_W      = 13;
  localparam int CHAR_W   = 8;
  localparam int SEG_W    = 3;
  localparam int MANT_W   = 4;
  localparam int MU_BIAS  = 33;
  localparam int SEG_N    = 1 << SEG_W;
  localparam int MAG_W    = LIN_W - 1;
  localparam int AMAG_W   = A_W - 1;
  localparam int MU_CLIP  = (1 << (LIN_W - 1)) - 1 - MU_BIAS;
  localparam int A_MAX    = (1 << (A_W - 1)) - 1;
  localparam logic [CHAR_W-1:0] A_EVEN_MASK = 8'h55;
  localparam logic [CHAR_W-1:0] MU_IDLE     = 8'hFF;

  typedef enum logic { LAW_MU = 1'b0, LAW_A = 1'b1 } law_e;

  typedef struct packed {
    logic              sign;
    logic [SEG_W-1:0]  seg;
    logic [MANT_W-1:0] mant;
  } code_t;
endpackage

// File: rtl/g711_rst_sync.sv
module g711_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/g711_lead_one.sv
module g711_lead_one #(
  parameter int W     = 8,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             found
);
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        idx   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/g711_encoder.sv
module g711_encoder
  import g711_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              law,
  input  logic              in_valid,
  input  logic [LIN_W-1:0]  lin_in,
  output logic              out_valid,
  output logic [CHAR_W-1:0] char_out
);
  localparam int MU_LO = MAG_W - SEG_N;
  localparam int A_LO  = AMAG_W - (SEG_N - 1);

  // mu-law path
  logic [LIN_W-1:0]  mu_abs;
  logic [MAG_W-1:0]  mu_mag, mu_biased, mu_shift;
  logic [SEG_W-1:0]  mu_seg;
  logic              mu_found;
  code_t             mu_code;

  always_comb begin
    mu_abs    = lin_in[LIN_W-1] ? (~lin_in + LIN_W'(1)) : lin_in;
    mu_mag    = (mu_abs > LIN_W'(MU_CLIP)) ? MAG_W'(MU_CLIP) : mu_abs[MAG_W-1:0];
    mu_biased = mu_mag + MAG_W'(MU_BIAS);
  end

  g711_lead_one #(.W(SEG_N), .IDX_W(SEG_W)) u_mu_lead (
    .vec   (mu_biased[MAG_W-1:MU_LO]),
    .idx   (mu_seg),
    .found (mu_found)
  );

  always_comb begin
    mu_shift     = mu_biased >> ({1'b0, mu_seg} + 4'd1);
    mu_code.sign = lin_in[LIN_W-1];
    mu_code.seg  = mu_seg;
    mu_code.mant = mu_shift[MANT_W-1:0];
  end

  // A-law path
  logic [A_W-1:0]    a_x, a_abs;
  logic [AMAG_W-1:0] a_mag, a_shift;
  logic [SEG_W-1:0]  a_idx, a_seg;
  logic              a_found;
  code_t             a_code;

  always_comb begin
    a_x   = lin_in[A_W-1:0];
    a_abs = a_x[A_W-1] ? (~a_x + A_W'(1)) : a_x;
    a_mag = (a_abs > A_W'(A_MAX)) ? AMAG_W'(A_MAX) : a_abs[AMAG_W-1:0];
  end

  g711_lead_one #(.W(SEG_N - 1), .IDX_W(SEG_W)) u_a_lead (
    .vec   (a_mag[AMAG_W-1:A_LO]),
    .idx   (a_idx),
    .found (a_found)
  );

  always_comb begin
    a_seg       = a_found ? (a_idx + SEG_W'(1)) : '0;
    a_shift     = a_mag >> a_seg;
    a_code.sign = ~a_x[A_W-1];
    a_code.seg  = a_seg;
    a_code.mant = a_found ? a_shift[MANT_W-1:0] : a_mag[MANT_W:1];
  end

  // next state and registers
  logic              valid_d, valid_q;
  logic [CHAR_W-1:0] char_d, char_q;

  always_comb begin
    valid_d = in_valid;
    char_d  = (law == LAW_A) ? (a_code ^ A_EVEN_MASK) : ~mu_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      char_q  <= MU_IDLE;
    end else begin
      valid_q <= valid_d;
      if (in_valid) char_q <= char_d;
    end
  end

  assign out_valid = valid_q;
  assign char_out  = char_q;

  // R7
  enc_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R8
  enc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(char_out)));
  // R1
  enc_mu_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && law == LAW_MU && !lin_in[LIN_W-1]) |=> char_out[CHAR_W-1]);
  // R3
  enc_a_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && law == LAW_A) |=> (char_out[CHAR_W-1] == !$past(lin_in[A_W-1])));
  // R1
  enc_mu_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && law == LAW_MU && lin_in == '0) |=> (char_out == MU_IDLE));
endmodule

// File: rtl/g711_decoder.sv
module g711_decoder
  import g711_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              law,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] char_in,
  output logic              out_valid,
  output logic [LIN_W-1:0]  lin_out
);
  // mu-law path
  code_t             mu_c;
  logic [MANT_W+1:0] mu_mid;
  logic [MAG_W-1:0]  mu_up, mu_mag;
  logic [LIN_W-1:0]  mu_lin;

  always_comb begin
    mu_c   = ~char_in;
    mu_mid = {1'b1, mu_c.mant, 1'b1};
    mu_up  = MAG_W'(mu_mid) << mu_c.seg;
    mu_mag = mu_up - MAG_W'(MU_BIAS);
    mu_lin = mu_c.sign ? (LIN_W'(0) - {1'b0, mu_mag}) : {1'b0, mu_mag};
  end

  // A-law path
  code_t             a_c;
  logic [MANT_W+1:0] a_mid;
  logic [AMAG_W-1:0] a_mag;
  logic [A_W-1:0]    a_signed;
  logic [LIN_W-1:0]  a_lin;

  always_comb begin
    a_c   = char_in ^ A_EVEN_MASK;
    a_mid = {1'b1, a_c.mant, 1'b1};
    if (a_c.seg == '0) a_mag = AMAG_W'({a_c.mant, 1'b1});
    else               a_mag = AMAG_W'(a_mid) << (a_c.seg - SEG_W'(1));
    a_signed = a_c.sign ? {1'b0, a_mag} : (A_W'(0) - {1'b0, a_mag});
    a_lin    = {{(LIN_W-A_W){a_signed[A_W-1]}}, a_signed};
  end

  // next state and registers
  logic             valid_d, valid_q;
  logic [LIN_W-1:0] lin_d, lin_q;

  always_comb begin
    valid_d = in_valid;
    lin_d   = (law == LAW_A) ? a_lin : mu_lin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      lin_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (in_valid) lin_q <= lin_d;
    end
  end

  assign out_valid = valid_q;
  assign lin_out   = lin_q;

  // R7
  dec_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R8
  dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(lin_out)));
  // R5
  dec_pos_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && char_in[CHAR_W-1]) |=> !lin_out[LIN_W-1]);
  // R5
  dec_mu_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && law == LAW_MU && char_in[CHAR_W-2:0] == 7'h7F) |=> (lin_out == '0));
  // R6
  dec_a_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && law == LAW_A) |=> (lin_out != '0));
endmodule

// File: rtl/g711_codec.sv
module g711_codec
  import g711_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_law,
  input  logic              enc_valid_in,
  input  logic [LIN_W-1:0]  enc_lin_in,
  output logic              enc_valid_out,
  output logic [CHAR_W-1:0] enc_char_out,
  input  logic              dec_law,
  input  logic              dec_valid_in,
  input  logic [CHAR_W-1:0] dec_char_in,
  output logic              dec_valid_out,
  output logic [LIN_W-1:0]  dec_lin_out
);
  logic rst_sync_n;

  g711_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  g711_encoder u_enc (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .law       (enc_law),
    .in_valid  (enc_valid_in),
    .lin_in    (enc_lin_in),
    .out_valid (enc_valid_out),
    .char_out  (enc_char_out)
  );

  g711_decoder u_dec (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .law       (dec_law),
    .in_valid  (dec_valid_in),
    .char_in   (dec_char_in),
    .out_valid (dec_valid_out),
    .lin_out   (dec_lin_out)
  );
endmodule

// File: tb/g711_codec_bench.sv
`timescale 1ns/1ps
module g711_codec_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enc_law, enc_valid_in;
  logic [13:0] enc_lin_in;
  logic        enc_valid_out;
  logic [7:0]  enc_char_out;
  logic        dec_law, dec_valid_in;
  logic [7:0]  dec_char_in;
  logic        dec_valid_out;
  logic [13:0] dec_lin_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  g711_codec u_g711_codec (
    .clk(clk), .rst_n(rst_n),
    .enc_law(enc_law), .enc_valid_in(enc_valid_in), .enc_lin_in(enc_lin_in),
    .enc_valid_out(enc_valid_out), .enc_char_out(enc_char_out),
    .dec_law(dec_law), .dec_valid_in(dec_valid_in), .dec_char_in(dec_char_in),
    .dec_valid_out(dec_valid_out), .dec_lin_out(dec_lin_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench models, written from the requirement formulas
  function automatic logic [7:0] mdl_mu_enc(input int x);
    int mag, b, seg, mant;
    mag = (x < 0) ? -x : x;
    if (mag > 8158) mag = 8158;
    b = mag + 33;
    seg = 0;
    for (int s = 1; s < 8; s++) if (b >= (32 << s)) seg = s;
    mant = (b >> (seg + 1)) & 15;
    return ~8'(((x < 0) ? 128 : 0) + seg * 16 + mant);
  endfunction

  function automatic logic [7:0] mdl_a_enc(input int x);
    int mag, seg, mant;
    mag = (x < 0) ? -x : x;
    if (mag > 4095) mag = 4095;
    seg = 0;
    for (int s = 1; s < 8; s++) if (mag >= (16 << s)) seg = s;
    mant = (seg == 0) ? (mag >> 1) : ((mag >> seg) & 15);
    return 8'(((x < 0) ? 0 : 128) + seg * 16 + mant) ^ 8'h55;
  endfunction

  function automatic int mdl_mu_dec(input logic [7:0] ch);
    int c, mag;
    c = int'(~ch);
    mag = ((2 * (c & 15) + 33) << ((c >> 4) & 7)) - 33;
    return ((c & 128) != 0) ? -mag : mag;
  endfunction

  function automatic int mdl_a_dec(input logic [7:0] ch);
    int c, seg, m, mag;
    c = int'(ch ^ 8'h55);
    seg = (c >> 4) & 7;
    m = c & 15;
    mag = (seg == 0) ? (2 * m + 1) : ((2 * m + 33) << (seg - 1));
    return ((c & 128) != 0) ? mag : -mag;
  endfunction

  function automatic int sgn14(input logic [13:0] v);
    return int'($signed(v));
  endfunction

  task automatic enc_one(input logic law, input logic [13:0] lin, input logic [7:0] exp, input string req);
    @(negedge clk);
    enc_law = law; enc_lin_in = lin; enc_valid_in = 1'b1;
    @(negedge clk);
    enc_valid_in = 1'b0;
    chk(enc_valid_out === 1'b1 && enc_char_out === exp, req, int'(enc_char_out), int'(exp));
  endtask

  task automatic dec_one(input logic law, input logic [7:0] ch, input int exp, input string req);
    @(negedge clk);
    dec_law = law; dec_char_in = ch; dec_valid_in = 1'b1;
    @(negedge clk);
    dec_valid_in = 1'b0;
    chk(dec_valid_out === 1'b1 && sgn14(dec_lin_out) == exp, req, sgn14(dec_lin_out), exp);
  endtask

  task automatic t_reset();
    chk(enc_valid_out === 1'b0, "R10 enc valid", int'(enc_valid_out), 0);
    chk(enc_char_out === 8'hFF, "R10 enc char", int'(enc_char_out), 255);
    chk(dec_valid_out === 1'b0, "R10 dec valid", int'(dec_valid_out), 0);
    chk(dec_lin_out === 14'd0, "R10 dec lin", sgn14(dec_lin_out), 0);
  endtask

  task automatic t_mu_encode();
    enc_one(1'b0, 14'd0, 8'hFF, "R1 mu zero");
    enc_one(1'b0, 14'd8191, 8'h80, "R1 mu +full");
    enc_one(1'b0, 14'd8158, 8'h80, "R1 mu clip edge");
    enc_one(1'b0, 14'd100, mdl_mu_enc(100), "R1 mu 100");
    enc_one(1'b0, 14'h2000, 8'h00, "R2 mu -full");
    enc_one(1'b0, 14'(-1), mdl_mu_enc(-1), "R2 mu -1");
    enc_one(1'b0, 14'(-500), mdl_mu_enc(-500), "R2 mu -500");
  endtask

  task automatic t_a_encode();
    enc_one(1'b1, 14'd0, 8'hD5, "R3 A zero");
    enc_one(1'b1, 14'd4095, 8'hAA, "R3 A +full");
    enc_one(1'b1, 14'h3000, 8'h2A, "R3 A -full");
    enc_one(1'b1, 14'h3FFF, 8'h55, "R3 A -1");
    enc_one(1'b1, 14'd32, mdl_a_enc(32), "R3 A seg1 edge");
  endtask

  task automatic t_a_seg0();
    for (int k = 0; k < 16; k++)
      enc_one(1'b1, 14'(2 * k), (8'h80 | 8'(k)) ^ 8'h55, "R4 A seg0 linear");
    enc_one(1'b1, 14'd31, (8'h8F) ^ 8'h55, "R4 A seg0 top");
  endtask

  task automatic t_a_bit13();
    enc_one(1'b1, 14'h2000 | 14'd700, mdl_a_enc(700), "R9 bit13 set on positive");
    enc_one(1'b1, 14'h1000 | 14'd5, mdl_a_enc(-4096 + 5), "R9 bit13 clear on negative");
  endtask

  task automatic t_enc_stream();
    logic [7:0] exp_prev;
    exp_prev = 8'h00;
    for (int i = 0; i < 440; i++) begin
      int x;
      logic law;
      @(negedge clk);
      if (i > 0)
        chk(enc_valid_out === 1'b1 && enc_char_out === exp_prev, "R7 R11 enc stream",
            int'(enc_char_out), int'(exp_prev));
      law = i[0];
      if (law) begin
        x = -4096 + i * 18;
        exp_prev = mdl_a_enc(x);
      end else begin
        x = -8192 + i * 37;
        exp_prev = mdl_mu_enc(x);
      end
      enc_law = law; enc_lin_in = 14'(x); enc_valid_in = 1'b1;
    end
    @(negedge clk);
    enc_valid_in = 1'b0;
    chk(enc_valid_out === 1'b1 && enc_char_out === exp_prev, "R7 enc stream last",
        int'(enc_char_out), int'(exp_prev));
  endtask

  task automatic t_decode();
    dec_one(1'b0, 8'hFF, 0, "R5 mu +zero");
    dec_one(1'b0, 8'h7F, 0, "R5 mu -zero");
    dec_one(1'b0, 8'h80, 8031, "R5 mu +full");
    dec_one(1'b0, 8'h00, -8031, "R5 mu -full");
    dec_one(1'b1, 8'hD5, 1, "R6 A +zero");
    dec_one(1'b1, 8'h55, -1, "R6 A -zero");
    dec_one(1'b1, 8'hAA, 4032, "R6 A +full");
    dec_one(1'b1, 8'h2A, -4032, "R6 A -full");
  endtask

  task automatic t_dec_stream();
    int exp_prev;
    exp_prev = 0;
    for (int i = 0; i < 512; i++) begin
      logic law;
      logic [7:0] ch;
      @(negedge clk);
      if (i > 0)
        chk(dec_valid_out === 1'b1 && sgn14(dec_lin_out) == exp_prev, "R11 R5 R6 dec stream",
            sgn14(dec_lin_out), exp_prev);
      law = i[0];
      ch = 8'(i >> 1);
      exp_prev = law ? mdl_a_dec(ch) : mdl_mu_dec(ch);
      dec_law = law; dec_char_in = ch; dec_valid_in = 1'b1;
    end
    @(negedge clk);
    dec_valid_in = 1'b0;
    chk(dec_valid_out === 1'b1 && sgn14(dec_lin_out) == exp_prev, "R7 dec stream last",
        sgn14(dec_lin_out), exp_prev);
  endtask

  task automatic t_hold();
    logic [7:0]  c_keep;
    logic [13:0] l_keep;
    enc_one(1'b0, 14'd1234, mdl_mu_enc(1234), "R8 enc setup");
    dec_one(1'b1, 8'h3C, mdl_a_dec(8'h3C), "R8 dec setup");
    c_keep = enc_char_out;
    l_keep = dec_lin_out;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      enc_law = ~enc_law; enc_lin_in = 14'(j * 999 + 7);
      dec_law = ~dec_law; dec_char_in = 8'(j * 71 + 3);
    end
    @(negedge clk);
    chk(enc_valid_out === 1'b0 && enc_char_out === c_keep, "R8 enc hold",
        int'(enc_char_out), int'(c_keep));
    chk(dec_valid_out === 1'b0 && dec_lin_out === l_keep, "R8 dec hold",
        sgn14(dec_lin_out), sgn14(l_keep));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    enc_law = 1'b0; enc_valid_in = 1'b0; enc_lin_in = '0;
    dec_law = 1'b0; dec_valid_in = 1'b0; dec_char_in = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_mu_encode();
    t_a_encode();
    t_a_seg0();
    t_a_bit13();
    t_enc_stream();
    t_decode();
    t_dec_stream();
    t_hold();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule